// File: doc/BRIEF.md
# Reference Clock Source Selector

This block chooses which 10 MHz reference the system clock phase-lock stage follows. It watches two external candidates, one from the timing-module pin and one from the rear-panel input. It checks each against a free-running internal sampling clock and steers a 2-bit select code to the downstream phase-lock loop. When neither candidate carries a valid reference, it falls back to the internal self-generated source. Switching is automatic and needs no software action.

Each input first passes through a synchronizer and a rising-edge detector. Its edges are then counted over a fixed gate window of `GATE_CYC` sampling cycles. A window passes when its count lies inside a programmable band. With a 100 MHz sampling clock and a 100 000-cycle window, for example, a ±100 ppm tolerance on a 10 MHz input is a band of 9999 to 10001 edges. A hysteresis stage keeps the select code from chattering. Alongside the select code, the block gives a one-cycle change pulse, the per-input present flags and a read-only status word.

Top module: `ref_sel_top`

## Requirements
- R1: After reset release, consecutive gate windows of exactly `GATE_CYC` sampling cycles each start on the first sampling edge. In each window the block counts the rising edges of each input, taken after a two-flop synchronizer.
- R2: A window passes for an input when its edge count c satisfies `band_min_i <= c <= band_max_i`, with both bounds inclusive. The band ports are live: a changed band applies from the next window evaluated.
- R3: An input's present flag rises only at the end of the second consecutive passing window. One passing window alone does not set it.
- R4: A present flag falls only at the end of the second consecutive failing window. A single failing window between passing windows leaves the flag, the select code and the change pulse untouched.
- R5: The select code is 2'b10 (timing module) whenever the timing-module input is present, whatever the rear input does. It is 2'b01 (rear) when only the rear input is present, and 2'b00 (internal) when neither is present. The code 2'b11 never appears.
- R6: `sel_o` follows the present flags one sampling cycle after they change.
- R7: `sel_chg_o` is high for exactly one cycle, in the same cycle that `sel_o` takes a new value, and is low otherwise.
- R8: `status_o` bit 3 is the timing-module present flag, bit 2 is the rear present flag, and bits 1:0 are the current select code.
- R9: While reset is asserted, `sel_o` is 2'b00, both present flags are 0, `sel_chg_o` is 0 and `status_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running internal sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tm_ref_i | input | 1 | Timing-module reference candidate (asynchronous) |
| rear_ref_i | input | 1 | Rear-panel reference candidate (asynchronous) |
| band_min_i | input | CNT_W | Lowest edge count accepted per window |
| band_max_i | input | CNT_W | Highest edge count accepted per window |
| sel_o | output | 2 | Source select to the phase-lock stage |
| sel_chg_o | output | 1 | One-cycle pulse on a select change |
| tm_present_o | output | 1 | Timing-module input declared present |
| rear_present_o | output | 1 | Rear input declared present |
| status_o | output | 4 | Read-only status word |

## Verification
The bench builds the block with `GATE_CYC = 50`, `HYST_WIN = 2` and a band of 11 to 14 edges. It models a valid reference as a toggle every two sampling cycles, which gives 12 or 13 edges per window depending on phase. Toggles every cycle or every three cycles give counts far outside the band. With windows this short, every transition of the priority table, the exact two-window acquisition and the change-pulse cycle can be reached within a few hundred cycles each. A gap placed inside a single window can also be timed from reset, which exercises the single-failure hysteresis case.

// File: rtl/ref_sel_pkg.sv
package ref_sel_pkg;
  typedef enum logic [1:0] {
    SEL_INT  = 2'b00,
    SEL_REAR = 2'b01,
    SEL_TM   = 2'b10
  } ref_sel_e;

  localparam int unsigned NUM_REF  = 2;
  localparam int unsigned REF_REAR = 0;
  localparam int unsigned REF_TM   = 1;
endpackage

// File: rtl/ref_sync_edge.sv
module ref_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // two rises need at least one low sample between them
  assert_rise_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ref_gate_timer.sv
module ref_gate_timer #(
  parameter int unsigned GATE_CYC = 100000,
  localparam int unsigned TW = $clog2(GATE_CYC)
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic win_end_o
);
  logic [TW-1:0] cnt_q;

  assign win_end_o = (cnt_q == TW'(GATE_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (win_end_o) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  assert_gate_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < TW'(GATE_CYC));
endmodule

// File: rtl/ref_presence.sv
module ref_presence #(
  parameter int unsigned GATE_CYC = 100000,
  parameter int unsigned HYST_WIN = 2,
  localparam int unsigned CNT_W = $clog2(GATE_CYC + 1),
  localparam int unsigned RW    = $clog2(HYST_WIN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             win_end_i,
  input  logic [CNT_W-1:0] band_min_i,
  input  logic [CNT_W-1:0] band_max_i,
  output logic             present_o
);
  logic [CNT_W-1:0] edge_cnt_q;
  logic [CNT_W-1:0] win_total;
  logic             win_pass;
  logic [RW-1:0]    run_q;
  logic             present_q;

  // final count includes an edge seen in the closing cycle
  assign win_total = edge_cnt_q + CNT_W'(rise_i);
  assign win_pass  = (win_total >= band_min_i) && (win_total <= band_max_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        edge_cnt_q <= '0;
    else if (win_end_i) edge_cnt_q <= '0;
    else if (rise_i)    edge_cnt_q <= win_total;
  end

  // run_q counts consecutive windows that disagree with the current flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= '0;
      present_q <= 1'b0;
    end else if (win_end_i) begin
      if (win_pass == present_q) begin
        run_q <= '0;
      end else if (run_q == RW'(HYST_WIN - 1)) begin
        run_q     <= '0;
        present_q <= win_pass;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign present_o = present_q;

  assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_cnt_q <= CNT_W'(GATE_CYC));

  assert_flip_at_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(present_q) |-> $past(win_end_i));

  assert_run_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q < RW'(HYST_WIN));
endmodule

// File: rtl/ref_sel_top.sv
module ref_sel_top
  import ref_sel_pkg::*;
#(
  parameter int unsigned GATE_CYC    = 100000,
  parameter int unsigned HYST_WIN    = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W = $clog2(GATE_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tm_ref_i,
  input  logic             rear_ref_i,
  input  logic [CNT_W-1:0] band_min_i,
  input  logic [CNT_W-1:0] band_max_i,
  output logic [1:0]       sel_o,
  output logic             sel_chg_o,
  output logic             tm_present_o,
  output logic             rear_present_o,
  output logic [3:0]       status_o
);
  logic [NUM_REF-1:0] ref_in;
  logic [NUM_REF-1:0] rise;
  logic [NUM_REF-1:0] pres;
  logic               win_end;
  ref_sel_e           sel_next, sel_q;
  logic               chg_q;

  assign ref_in[REF_REAR] = rear_ref_i;
  assign ref_in[REF_TM]   = tm_ref_i;

  ref_gate_timer #(.GATE_CYC(GATE_CYC)) u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .win_end_o(win_end)
  );

  for (genvar g = 0; g < NUM_REF; g++) begin : g_ref
    ref_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(ref_in[g]),
      .rise_o (rise[g])
    );

    ref_presence #(.GATE_CYC(GATE_CYC), .HYST_WIN(HYST_WIN)) u_pres (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rise_i    (rise[g]),
      .win_end_i (win_end),
      .band_min_i(band_min_i),
      .band_max_i(band_max_i),
      .present_o (pres[g])
    );
  end

  always_comb begin
    if (pres[REF_TM])        sel_next = SEL_TM;
    else if (pres[REF_REAR]) sel_next = SEL_REAR;
    else                     sel_next = SEL_INT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= SEL_INT;
      chg_q <= 1'b0;
    end else begin
      sel_q <= sel_next;
      chg_q <= (sel_next != sel_q);
    end
  end

  assign sel_o          = sel_q;
  assign sel_chg_o      = chg_q;
  assign tm_present_o   = pres[REF_TM];
  assign rear_present_o = pres[REF_REAR];
  assign status_o       = {pres[REF_TM], pres[REF_REAR], sel_q};

  assert_sel_legal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q != 2'b11);

  assert_tm_priority_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pres[REF_TM] |=> sel_q == SEL_TM);

  assert_rear_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pres == 2'b01) |=> sel_q == SEL_REAR);

  assert_chg_on_move_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_chg_o |-> sel_o != $past(sel_o));

  assert_move_has_chg_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o != $past(sel_o) |-> sel_chg_o);
endmodule

// File: tb/ref_sel_top_tb_top.sv
`timescale 1ns/1ps
module ref_sel_top_tb_top;
  localparam int unsigned GATE  = 50;
  localparam int unsigned CW    = $clog2(GATE + 1);
  localparam int unsigned NROWS = 9;

  // row: tm_half[3:0], rear_half[3:0], exp_sel[1:0], exp_chg[1:0]; half 2 = valid
  localparam logic [11:0] TBL [NROWS] = '{
    {4'd0, 4'd0, 2'b00, 2'd0},
    {4'd0, 4'd2, 2'b01, 2'd1},
    {4'd2, 4'd2, 2'b10, 2'd1},
    {4'd2, 4'd0, 2'b10, 2'd0},
    {4'd3, 4'd0, 2'b00, 2'd1},
    {4'd3, 4'd3, 2'b00, 2'd0},
    {4'd3, 4'd2, 2'b01, 2'd1},
    {4'd1, 4'd2, 2'b01, 2'd0},
    {4'd1, 4'd0, 2'b00, 2'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tm_ref = 1'b0, rear_ref = 1'b0;
  logic [CW-1:0] bmin = CW'(11), bmax = CW'(14);
  logic [1:0] sel;
  logic chg, tm_p, rear_p;
  logic [3:0] status;
  int tm_half = 0, rear_half = 0;
  int cyc = 0, chg_cnt = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ref_sel_top #(.GATE_CYC(GATE), .HYST_WIN(2), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tm_ref_i(tm_ref), .rear_ref_i(rear_ref),
    .band_min_i(bmin), .band_max_i(bmax), .sel_o(sel), .sel_chg_o(chg),
    .tm_present_o(tm_p), .rear_present_o(rear_p), .status_o(status)
  );

  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && chg) chg_cnt <= chg_cnt + 1;

  initial forever begin
    if (tm_half == 0) begin tm_ref = 1'b0; @(negedge clk); end
    else begin repeat (tm_half) @(negedge clk); tm_ref = ~tm_ref; end
  end
  initial forever begin
    if (rear_half == 0) begin rear_ref = 1'b0; @(negedge clk); end
    else begin repeat (rear_half) @(negedge clk); rear_ref = ~rear_ref; end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    while (cyc != n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R9 reset sel", sel, 0);
    chk("R9 reset chg", chg, 0);
    chk("R9 reset status", status, 0);
    chk("R9 reset present", {tm_p, rear_p}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NROWS; i++) begin
      tm_half   = int'(TBL[i][11:8]);
      rear_half = int'(TBL[i][7:4]);
      chg_cnt   = 0;
      repeat (400) @(negedge clk);
      chk($sformatf("R5 row%0d sel", i), sel, int'(TBL[i][3:2]));
      chk($sformatf("R7 row%0d chg count", i), chg_cnt, int'(TBL[i][1:0]));
      chk($sformatf("R2 row%0d tm present", i), tm_p, int'(tm_half == 2));
      chk($sformatf("R2 row%0d rear present", i), rear_p, int'(rear_half == 2));
      chk($sformatf("R8 row%0d status", i), status,
          {29'd0, tm_half == 2, rear_half == 2, TBL[i][3:2]});
    end

    // R4: a gap inside one window causes only one failing window
    tm_half = 2; rear_half = 0;
    repeat (400) @(negedge clk);
    chk("R5 tm valid sel", sel, 2);
    while (cyc % GATE != 10) @(negedge clk);
    chg_cnt = 0;
    tm_half = 0;
    repeat (25) @(negedge clk);
    tm_half = 2;
    repeat (150) @(negedge clk);
    chk("R4 single fail keeps present", tm_p, 1);
    chk("R4 single fail keeps sel", sel, 2);
    chk("R4 single fail no chg", chg_cnt, 0);

    // R2: band moved away from the real count
    bmin = CW'(20); bmax = CW'(30);
    repeat (400) @(negedge clk);
    chk("R2 out of band drops present", tm_p, 0);
    chk("R2 out of band sel", sel, 0);
    bmin = CW'(11); bmax = CW'(14);
    repeat (400) @(negedge clk);
    chk("R2 band restored present", tm_p, 1);

    // R3/R6/R7: acquisition timing from reset with the input running
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 reset again sel", sel, 0);
    rst_n = 1'b1;
    wait_cyc(75);
    chk("R3 one window not present", tm_p, 0);
    chk("R3 one window sel", sel, 0);
    wait_cyc(100);
    chk("R3 two windows present", tm_p, 1);
    chk("R6 sel lags present", sel, 0);
    wait_cyc(101);
    chk("R6 sel follows", sel, 2);
    chk("R7 chg pulse", chg, 1);
    wait_cyc(102);
    chk("R7 chg one cycle", chg, 0);
    chk("R8 status after acquire", status, 4'b1010);

    finish_run();
  end
endmodule